// File: doc/BRIEF.md
# Glitch-Free Clock Divider Bank

This block runs on a fast oscillator-rate clock and drives six divided clock outputs plus one feedback clock for a phase comparator. A single free-running counter supplies every output, so all outputs share rising edges at the counter wrap. Two outputs run at half the input rate and four run at a quarter of it. The feedback output always runs at one eighth of the input rate.

A half-rate control doubles the divide ratio of all six outputs at once. The new ratio starts only at the counter wrap, which is the boundary of the slowest output. A two-bit stop control parks chosen groups of outputs low while the rest keep running. Every output starts and stops only on a full phase. Both controls are resynchronized internally and may be active together.

Top module: `clk_div_bank`

## Requirements
- R1: While rst_ni is low, every output and fb_clk_o are low. On the first rising clock edge after release, all six outputs and fb_clk_o go high together.
- R2: fb_clk_o is high for 4 cycles and low for 4 cycles at all times, whatever the state of pwr_dn_i and shut_i.
- R3: With pwr_dn_i low and no stop active, clk_o[0] and clk_o[1] divide the input clock by 2 (1 cycle high, 1 low), and clk_o[2] to clk_o[5] divide it by 4 (2 high, 2 low).
- R4: With pwr_dn_i high, every running output divides by twice its normal ratio: clk_o[1:0] by 4 and clk_o[5:2] by 8.
- R5: A change in pwr_dn_i takes effect only at a rising edge of fb_clk_o. During the change no output shows a high phase of any length other than its normal or doubled half period, and no low phase shorter than its normal half period.
- R6: shut_i[0] high stops clk_o[0], clk_o[1] and clk_o[4]. shut_i[1] high stops clk_o[2], clk_o[3] and clk_o[4]. clk_o[5] never stops.
- R7: A stopped output is held low. An output stops or restarts only after a complete low phase has begun, so every high phase it shows is a full half period.
- R8: The half-rate control and the stop control combine. Outputs that are not stopped run at the doubled ratio, and stopped outputs stay low.
- R9: In steady state, each running output rises on the same edge as every rising edge of fb_clk_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator-rate input clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_dn_i | input | 1 | Half-rate request, asynchronous |
| shut_i | input | 2 | Group stop requests, asynchronous |
| clk_o | output | 6 | Divided clock outputs |
| fb_clk_o | output | 1 | Divide-by-8 feedback clock |

## Verification
The checker assumes that clk_i is the only clock and that the block leaves reset with every counter at zero. Its run-length counters rely on this, because phase lengths are only meaningful when measured against clk_i. The controls are treated as fully asynchronous, so no assertion constrains when pwr_dn_i or shut_i may change. The bench changes the controls only just after a falling edge of clk_i. It holds each setting for longer than the synchronizer delay plus one feedback period, so every transition window closes before the next change.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  typedef enum logic {
    RATE_NORM = 1'b0,
    RATE_HALF = 1'b1
  } rate_e;

  localparam int DIV_FIELD_W = 2;
endpackage

// File: rtl/cdb_sync.sv
module cdb_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cdb_rate_ctrl.sv
module cdb_rate_ctrl
  import cdb_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_i,
  output logic [CNT_W-1:0] cnt_o,
  output rate_e            rate_o
);
  logic [CNT_W-1:0] cnt_q;
  rate_e            rate_q;

  // rate switches only on the wrap, where every divided clock is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      rate_q <= RATE_NORM;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (&cnt_q) rate_q <= half_i ? RATE_HALF : RATE_NORM;
    end
  end

  assign cnt_o  = cnt_q;
  assign rate_o = rate_q;
endmodule

// File: rtl/cdb_out_gate.sv
module cdb_out_gate
  import cdb_pkg::*;
#(
  parameter int CNT_W    = 3,
  parameter int DIV_LOG2 = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  rate_e            rate_i,
  input  logic             stop_i,
  output logic             clk_o
);
  localparam int TAP = DIV_LOG2 - 1;

  logic lvl, en_q, clk_q;

  assign lvl = (rate_i == RATE_HALF) ? ~cnt_i[TAP+1] : ~cnt_i[TAP];

  // enable moves only during a low phase, so phases are never cut short
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b1;
      clk_q <= 1'b0;
    end else begin
      clk_q <= en_q & lvl;
      if (!lvl) en_q <= ~stop_i;
    end
  end

  assign clk_o = clk_q;
endmodule

// File: rtl/clk_div_bank.sv
module clk_div_bank
  import cdb_pkg::*;
#(
  parameter int                          N_OUT    = 6,
  parameter int                          N_GRP    = 2,
  parameter int                          FB_LOG2  = 3,
  parameter logic [N_OUT*DIV_FIELD_W-1:0] DIV_LOG2 = {2'd2, 2'd2, 2'd2, 2'd2, 2'd1, 2'd1},
  parameter logic [N_OUT*N_GRP-1:0]       GRP_MASK = {2'b00, 2'b11, 2'b10, 2'b10, 2'b01, 2'b01}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pwr_dn_i,
  input  logic [N_GRP-1:0] shut_i,
  output logic [N_OUT-1:0] clk_o,
  output logic             fb_clk_o
);
  localparam int CNT_W = FB_LOG2;
  localparam int CTL_W = N_GRP + 1;

  logic [CTL_W-1:0] ctl_s;
  logic             half_s;
  logic [N_GRP-1:0] shut_s;
  logic [CNT_W-1:0] cnt;
  rate_e            rate;
  logic             fb_q;

  cdb_sync #(.W(CTL_W)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({pwr_dn_i, shut_i}),
    .q_o    (ctl_s)
  );

  assign half_s = ctl_s[CTL_W-1];
  assign shut_s = ctl_s[N_GRP-1:0];

  cdb_rate_ctrl #(.CNT_W(CNT_W)) u_rate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .half_i (half_s),
    .cnt_o  (cnt),
    .rate_o (rate)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    localparam int DL = int'(DIV_LOG2[g*DIV_FIELD_W +: DIV_FIELD_W]);
    logic stop;

    assign stop = |(shut_s & GRP_MASK[g*N_GRP +: N_GRP]);

    cdb_out_gate #(.CNT_W(CNT_W), .DIV_LOG2(DL)) u_gate (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cnt_i  (cnt),
      .rate_i (rate),
      .stop_i (stop),
      .clk_o  (clk_o[g])
    );
  end

  // feedback ignores both controls to keep the loop locked
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fb_q <= 1'b0;
    else         fb_q <= ~cnt[CNT_W-1];
  end

  assign fb_clk_o = fb_q;
endmodule

// File: rtl/clk_div_bank_chk.sv
module clk_div_bank_chk #(
  parameter int               N_OUT    = 6,
  parameter logic [N_OUT*2-1:0] DIV_LOG2 = {2'd2, 2'd2, 2'd2, 2'd2, 2'd1, 2'd1}
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_OUT-1:0] clk_o,
  input logic             fb_clk_o
);
  logic             fb_d, fb_seen;
  logic [3:0]       fb_run, lo_last;
  logic [N_OUT-1:0] clk_d;
  logic [3:0]       hi_run [N_OUT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_d    <= 1'b0;
      fb_seen <= 1'b0;
      fb_run  <= '0;
      lo_last <= '0;
      clk_d   <= '0;
      for (int i = 0; i < N_OUT; i++) hi_run[i] <= '0;
    end else begin
      fb_d  <= fb_clk_o;
      clk_d <= clk_o;
      if (fb_clk_o != fb_d) begin
        fb_run  <= '0;
        fb_seen <= 1'b1;
      end else if (fb_run != 4'hf) begin
        fb_run <= fb_run + 1'b1;
      end
      if (clk_o[N_OUT-1])       lo_last <= '0;
      else if (lo_last != 4'hf) lo_last <= lo_last + 1'b1;
      for (int i = 0; i < N_OUT; i++) begin
        if (!clk_o[i])              hi_run[i] <= '0;
        else if (hi_run[i] != 4'hf) hi_run[i] <= hi_run[i] + 1'b1;
      end
    end
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_low_chk: assert (clk_o == '0 && !fb_clk_o);
    end
  end

  // R2
  fb_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fb_clk_o != fb_d && fb_seen) |-> fb_run == 4'd3);

  // R9
  phase_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fb_clk_o) |-> (clk_o & $past(clk_o)) == '0);

  // R6
  always_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lo_last <= 4'd4);

  for (genvar g = 0; g < N_OUT; g++) begin : g_hi
    localparam int MIN_H = 1 << (int'(DIV_LOG2[g*2 +: 2]) - 1);
    // R7
    full_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clk_d[g] && !clk_o[g]) |-> (hi_run[g] >= 4'(MIN_H) && hi_run[g] <= 4'(2*MIN_H)));
  end
endmodule

bind clk_div_bank clk_div_bank_chk #(
  .N_OUT    (N_OUT),
  .DIV_LOG2 (DIV_LOG2)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .clk_o    (clk_o),
  .fb_clk_o (fb_clk_o)
);

// File: tb/clk_div_bank_tb.sv
module clk_div_bank_tb;
  localparam int N_OUT = 6;
  localparam int NS    = N_OUT + 1;

  logic             clk_i    = 1'b0;
  logic             rst_ni   = 1'b1;
  logic             pwr_dn_i = 1'b0;
  logic [1:0]       shut_i   = '0;
  logic [N_OUT-1:0] clk_o;
  logic             fb_clk_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk_i = ~clk_i;

  clk_div_bank u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .pwr_dn_i (pwr_dn_i),
    .shut_i   (shut_i),
    .clk_o    (clk_o),
    .fb_clk_o (fb_clk_o)
  );

  // {pwr_dn, shut[1:0], expected stop mask clk_o[5:0]} per R6
  localparam logic [8:0] VEC [8] = '{
    {1'b0, 2'b00, 6'b000000},
    {1'b0, 2'b01, 6'b010011},
    {1'b0, 2'b10, 6'b011100},
    {1'b0, 2'b11, 6'b011111},
    {1'b1, 2'b11, 6'b011111},
    {1'b1, 2'b10, 6'b011100},
    {1'b1, 2'b01, 6'b010011},
    {1'b1, 2'b00, 6'b000000}
  };

  int exp_h [NS];
  int nrm_h [NS];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic set_exp(input bit pd, input logic [5:0] stop);
    for (int i = 0; i < NS; i++) begin
      nrm_h[i] = (i == N_OUT) ? 4 : (i < 2 ? 1 : 2);
      if (i == N_OUT)    exp_h[i] = 4;
      else if (stop[i])  exp_h[i] = 0;
      else               exp_h[i] = nrm_h[i] << pd;
    end
  endtask

  // strict: steady-state run lengths; otherwise: transition bounds (R5, R7)
  task automatic watch(input int ncyc, input bit strict, input bit pd, input logic [5:0] stop);
    logic [NS-1:0] prev, cur;
    int run [NS];
    bit started [NS];
    int ndone [NS];
    int nbad [NS];
    int badlen [NS];
    int nhigh [NS];
    int misalign;
    string req;
    misalign = 0;
    @(negedge clk_i);
    prev = {fb_clk_o, clk_o};
    for (int i = 0; i < NS; i++) begin
      run[i] = 1; started[i] = 1'b0; ndone[i] = 0; nbad[i] = 0; badlen[i] = 0; nhigh[i] = 0;
    end
    for (int c = 1; c < ncyc; c++) begin
      @(negedge clk_i);
      cur = {fb_clk_o, clk_o};
      for (int i = 0; i < NS; i++) begin
        if (cur[i]) nhigh[i]++;
        if (cur[i] != prev[i]) begin
          if (started[i]) begin
            bit ok;
            if (strict || i == N_OUT) ok = (run[i] == exp_h[i]);
            else if (prev[i])         ok = (run[i] == nrm_h[i] || run[i] == 2*nrm_h[i]);
            else                      ok = (run[i] >= nrm_h[i]);
            if (!ok) begin nbad[i]++; badlen[i] = run[i]; end
            ndone[i]++;
          end
          started[i] = 1'b1;
          run[i] = 1;
        end else begin
          run[i]++;
        end
      end
      if (strict && cur[N_OUT] && !prev[N_OUT]) begin
        for (int i = 0; i < N_OUT; i++)
          if (exp_h[i] != 0 && !(cur[i] && !prev[i])) misalign++;
      end
      prev = cur;
    end
    for (int i = 0; i < NS; i++) begin
      if (i == N_OUT)      req = "R2";
      else if (!strict)    req = "R5,R7";
      else if (exp_h[i] == 0) req = pd ? "R8" : "R6";
      else if (pd)         req = (stop != 0) ? "R8" : "R4";
      else                 req = "R3";
      if (strict && i < N_OUT && exp_h[i] == 0)
        check(nhigh[i] == 0, req, $sformatf("stopped out%0d high samples", i), nhigh[i], 0);
      else if (strict)
        check(nbad[i] == 0 && ndone[i] > 0, req, $sformatf("sig%0d run length", i),
              nbad[i] != 0 ? badlen[i] : 0, exp_h[i]);
      else
        check(nbad[i] == 0, req, $sformatf("sig%0d transition run", i), badlen[i], nrm_h[i]);
    end
    if (strict) check(misalign == 0, "R9", "outputs not rising with feedback", misalign, 0);
  endtask

  task automatic reset_and_start(input string tag);
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check(clk_o == '0 && !fb_clk_o, "R1", {tag, " outputs during reset"},
          int'({fb_clk_o, clk_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(clk_o == '1 && fb_clk_o, "R1", {tag, " first edge after reset"},
          int'({fb_clk_o, clk_o}), 127);
  endtask

  initial begin
    #1;
    reset_and_start("power-on");
    set_exp(1'b0, 6'b0);
    watch(64, 1'b1, 1'b0, 6'b0);

    for (int v = 0; v < 8; v++) begin
      @(negedge clk_i);
      pwr_dn_i = VEC[v][8];
      shut_i   = VEC[v][7:6];
      set_exp(VEC[v][8], VEC[v][5:0]);
      watch(40, 1'b0, VEC[v][8], VEC[v][5:0]);
      watch(64, 1'b1, VEC[v][8], VEC[v][5:0]);
    end

    // reset in the middle of half-rate operation with all groups stopped
    @(negedge clk_i);
    shut_i = 2'b11;
    repeat (30) @(negedge clk_i);
    pwr_dn_i = 1'b0;
    shut_i   = 2'b00;
    reset_and_start("mid-run");
    set_exp(1'b0, 6'b0);
    watch(64, 1'b1, 1'b0, 6'b0);

    // R5: quick return from half rate
    pwr_dn_i = 1'b1;
    repeat (20) @(negedge clk_i);
    pwr_dn_i = 1'b0;
    watch(40, 1'b0, 1'b0, 6'b0);
    watch(64, 1'b1, 1'b0, 6'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule